// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block sequences one programmed-I/O transfer at a time on a parallel IDE/ATA drive bus shared by up to four drives. Each drive owns a small set of timing fields: an address-setup code, a timing byte whose high nibble sets how long the read or write strobe stays asserted and whose low nibble sets the recovery gap after it, and a transfer-mode code that says whether the drive accepts programmed-I/O cycles at all. The clocks are counted at 33 MHz, so every count step is 30 ns.

A request carries a drive number, a direction flag and a 16-bit write value. Once accepted, the block raises an address-valid signal together with the selected drive number, holds it through a setup phase, asserts exactly one strobe for the active phase, drops the strobe for the recovery phase, and ends with a one-clock done pulse. Read data is sampled from the drive bus on the final active clock. A request for a drive whose mode code is not programmed-I/O is refused with a one-clock error pulse and no bus activity.

The timing fields are loaded through a simple write port that updates one drive's fields in one clock. The counts for a cycle are frozen at the moment the request is accepted.

Top module: `pio_cycle_gen`

## Requirements
- R1: The address-setup code gives 00 = 4 clocks, 01 = 2, 10 = 3, 11 = 5. From the clock after acceptance, bus_addr_valid is high and both strobes low for exactly that many clocks, and bus_sel_drive shows the requested drive while bus_addr_valid is high.
- R2: The high nibble of the timing byte (bits 7:4) gives the active time: 0 = 16 clocks, otherwise the nibble value. During it exactly one strobe is high: bus_rd_stb when req_write was 0, bus_wr_stb when it was 1.
- R3: The low nibble (bits 3:0) gives the recovery time: 0 = 16 clocks, 15 = 1 clock, otherwise the value plus one. During it both strobes are low and bus_addr_valid stays high.
- R4: After recovery, done is high for exactly one clock with bus_addr_valid low, and req_ready is high on the following clock.
- R5: After reset every drive has setup code 10, timing byte 0x00 and mode 00; req_ready is 1 and bus_addr_valid, both strobes, bus_data_oe, done, err and rd_data are 0.
- R6: On a read, rd_data takes the value on bus_data_in at the last active clock and keeps it until the next read captures.
- R7: On a write, bus_data_oe is high and bus_data_out equals the request's write value for the whole setup, active and recovery span; bus_data_oe is low otherwise.
- R8: A request for a drive whose mode code is not 00 (11 marks Ultra DMA) gives err high for one clock on the clock after acceptance, with no address-valid or strobe activity, and req_ready returns the clock after.
- R9: req_valid is ignored while req_ready is low; such requests leave the running cycle and its outputs unchanged and start nothing.
- R10: A field write accepted on the same clock as a request for that drive, or during a running cycle, does not change that cycle's counts; it applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for one drive's timing fields |
| cfg_drive | input | 2 | Drive whose fields are written |
| cfg_setup | input | 2 | Address-setup code |
| cfg_timing | input | 8 | Active nibble (7:4) and recovery nibble (3:0) |
| cfg_mode | input | 2 | Transfer mode code, 00 = programmed I/O |
| req_valid | input | 1 | Request present |
| req_drive | input | 2 | Target drive |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | 16 | Value to drive on a write |
| req_ready | output | 1 | Block idle, a request is taken this clock |
| bus_sel_drive | output | 2 | Drive addressed by the current cycle |
| bus_addr_valid | output | 1 | Address and chip select valid |
| bus_rd_stb | output | 1 | Read strobe, active high |
| bus_wr_stb | output | 1 | Write strobe, active high |
| bus_data_out | output | 16 | Write data towards the drive |
| bus_data_oe | output | 1 | Write data output enable |
| bus_data_in | input | 16 | Data from the drive |
| rd_data | output | 16 | Captured read value |
| done | output | 1 | One-clock cycle-complete pulse |
| err | output | 1 | One-clock refusal pulse |

## Verification
The two functions that can meet on one clock are a field write and the acceptance of a request for the same drive; the bench raises cfg_we and req_valid on the same clock with a timing byte whose nibbles differ from the current ones, and judges by the strobe and recovery lengths measured at the ports, which must follow the old byte, while the following request must follow the new one. A field write in the middle of a running cycle and requests held during a busy cycle are judged the same way, against a behavioural model compared on every clock.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_RECOV  = 3'd3,
        PH_DONE   = 3'd4,
        PH_ERR    = 3'd5
    } phase_e;

    typedef struct packed {
        logic [1:0] setup;
        logic [7:0] timing;
        logic [1:0] mode;
    } drv_cfg_t;

    localparam drv_cfg_t CFG_RESET = '{setup: 2'b10, timing: 8'h00, mode: 2'b00};

    // address-setup code to clock count (nonlinear)
    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b00:   n = CNT_W'(4);
            2'b01:   n = CNT_W'(2);
            2'b10:   n = CNT_W'(3);
            default: n = CNT_W'(5);
        endcase
        return n;
    endfunction

    // strobe-asserted nibble: zero means the longest span
    function automatic logic [CNT_W-1:0] active_clocks(input logic [3:0] code);
        return (code == 4'd0) ? CNT_W'(16) : CNT_W'(code);
    endfunction

    // strobe-released nibble: zero longest, all-ones shortest, else code+1
    function automatic logic [CNT_W-1:0] recovery_clocks(input logic [3:0] code);
        logic [CNT_W-1:0] n;
        if (code == 4'd0)       n = CNT_W'(16);
        else if (code == 4'hF)  n = CNT_W'(1);
        else                    n = CNT_W'(code) + CNT_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/pio_drive_regs.sv
module pio_drive_regs
    import pio_tim_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DRV_W-1:0] wr_drive,
    input  drv_cfg_t         wr_cfg,
    input  logic [DRV_W-1:0] rd_drive,
    output drv_cfg_t         rd_cfg
);

    drv_cfg_t bank [NUM_DRIVES];

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        drv_cfg_t cfg_d, cfg_q;

        always_comb begin
            cfg_d = cfg_q;
            if (wr_en && (wr_drive == DRV_W'(g))) begin
                cfg_d = wr_cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q <= CFG_RESET;
            else        cfg_q <= cfg_d;
        end

        assign bank[g] = cfg_q;
    end

    assign rd_cfg = bank[rd_drive];

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_tim_pkg::*;
(
    input  drv_cfg_t         cfg,
    output logic [CNT_W-1:0] setup_n,
    output logic [CNT_W-1:0] active_n,
    output logic [CNT_W-1:0] recov_n,
    output logic             pio_ok
);

    always_comb begin
        setup_n  = setup_clocks(cfg.setup);
        active_n = active_clocks(cfg.timing[7:4]);
        recov_n  = recovery_clocks(cfg.timing[3:0]);
        pio_ok   = (cfg.mode == 2'b00);
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_tim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DRV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  setup_n,
    input  logic [CNT_W-1:0]  active_n,
    input  logic [CNT_W-1:0]  recov_n,
    input  logic              pio_ok,
    input  logic [DATA_W-1:0] data_in,
    output logic              ready,
    output logic [DRV_W-1:0]  sel_drive,
    output logic              addr_valid,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err
);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  left;
        logic [CNT_W-1:0]  act;
        logic [CNT_W-1:0]  rec;
        logic              wr;
        logic [DRV_W-1:0]  drv;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.drv   = req_drive;
                    st_d.wr    = req_write;
                    st_d.wdata = req_wdata;
                    st_d.act   = active_n;
                    st_d.rec   = recov_n;
                    if (pio_ok) begin
                        st_d.phase = PH_SETUP;
                        st_d.left  = setup_n;
                    end else begin
                        st_d.phase = PH_ERR;
                    end
                end
            end
            PH_SETUP: begin
                if (st_q.left == CNT_W'(1)) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.left  = st_q.act;
                end else begin
                    st_d.left = st_q.left - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (st_q.left == CNT_W'(1)) begin
                    st_d.phase = PH_RECOV;
                    st_d.left  = st_q.rec;
                    if (!st_q.wr) st_d.rdata = data_in;
                end else begin
                    st_d.left = st_q.left - CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (st_q.left == CNT_W'(1)) st_d.phase = PH_DONE;
                else                        st_d.left  = st_q.left - CNT_W'(1);
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic busy_bus;
    assign busy_bus   = (st_q.phase == PH_SETUP) || (st_q.phase == PH_ACTIVE) ||
                        (st_q.phase == PH_RECOV);
    assign ready      = (st_q.phase == PH_IDLE);
    assign sel_drive  = st_q.drv;
    assign addr_valid = busy_bus;
    assign rd_stb     = (st_q.phase == PH_ACTIVE) && !st_q.wr;
    assign wr_stb     = (st_q.phase == PH_ACTIVE) && st_q.wr;
    assign data_oe    = busy_bus && st_q.wr;
    assign data_out   = st_q.wdata;
    assign rd_data    = st_q.rdata;
    assign done       = (st_q.phase == PH_DONE);
    assign err        = (st_q.phase == PH_ERR);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    assert_strobe_inside_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> addr_valid);

    assert_cycle_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(ready) && !rd_stb && !wr_stb);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid ##1 (!done && ready));

    assert_refusal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !addr_valid && !rd_stb && !wr_stb ##1 ready);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (addr_valid && $stable(sel_drive)) || done);

    assert_write_data_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_tim_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int DATA_W     = 16,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DRV_W-1:0]  cfg_drive,
    input  logic [1:0]        cfg_setup,
    input  logic [7:0]        cfg_timing,
    input  logic [1:0]        cfg_mode,
    input  logic              req_valid,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DRV_W-1:0]  bus_sel_drive,
    output logic              bus_addr_valid,
    output logic              bus_rd_stb,
    output logic              bus_wr_stb,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err
);

    drv_cfg_t         wr_cfg, sel_cfg;
    logic [CNT_W-1:0] setup_n, active_n, recov_n;
    logic             pio_ok;

    assign wr_cfg = '{setup: cfg_setup, timing: cfg_timing, mode: cfg_mode};

    pio_drive_regs #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_drive (cfg_drive),
        .wr_cfg   (wr_cfg),
        .rd_drive (req_drive),
        .rd_cfg   (sel_cfg)
    );

    pio_timing_decode u_dec (
        .cfg      (sel_cfg),
        .setup_n  (setup_n),
        .active_n (active_n),
        .recov_n  (recov_n),
        .pio_ok   (pio_ok)
    );

    pio_phase_seq #(.DATA_W(DATA_W), .DRV_W(DRV_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_drive  (req_drive),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .setup_n    (setup_n),
        .active_n   (active_n),
        .recov_n    (recov_n),
        .pio_ok     (pio_ok),
        .data_in    (bus_data_in),
        .ready      (req_ready),
        .sel_drive  (bus_sel_drive),
        .addr_valid (bus_addr_valid),
        .rd_stb     (bus_rd_stb),
        .wr_stb     (bus_wr_stb),
        .data_out   (bus_data_out),
        .data_oe    (bus_data_oe),
        .rd_data    (rd_data),
        .done       (done),
        .err        (err)
    );

endmodule

// File: tb/pio_cycle_gen_test.sv
module pio_cycle_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_drive = '0;
    logic [1:0]  cfg_setup = '0;
    logic [7:0]  cfg_timing = '0;
    logic [1:0]  cfg_mode = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_drive = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, bus_addr_valid, bus_rd_stb, bus_wr_stb, bus_data_oe, done, err;
    logic [1:0]  bus_sel_drive;
    logic [15:0] bus_data_out, rd_data;
    logic [15:0] bus_data_in = 16'h1234;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pio_cycle_gen uut (.*);

    always @(negedge clk) bus_data_in <= bus_data_in + 16'h3B1D;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int setup_of(input int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int act_of(input int nib);
        if (nib == 0) return 16;
        return nib;
    endfunction

    function automatic int rec_of(input int nib);
        if (nib == 0) return 16;
        if (nib == 15) return 1;
        return nib + 1;
    endfunction

    // behavioural reference: phase 0 idle, 1 setup, 2 active, 3 recovery, 4 done, 5 refused
    int m_ph, m_left, m_act, m_rec, m_drv;
    bit m_wr;
    logic [15:0] m_wd, m_rd;
    int m_setup[4], m_tim[4], m_mode[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_drv = 0; m_wr = 0; m_wd = 0; m_rd = 0;
            for (int i = 0; i < 4; i++) begin
                m_setup[i] = 2; m_tim[i] = 0; m_mode[i] = 0;
            end
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_drv = req_drive; m_wr = req_write; m_wd = req_wdata;
                    m_act = act_of(m_tim[m_drv] / 16);
                    m_rec = rec_of(m_tim[m_drv] % 16);
                    if (m_mode[m_drv] != 0) m_ph = 5;
                    else begin m_ph = 1; m_left = setup_of(m_setup[m_drv]); end
                end
                1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = m_act; end end
                2: begin
                    if (m_left == 1 && !m_wr) m_rd = bus_data_in;
                    m_left--;
                    if (m_left == 0) begin m_ph = 3; m_left = m_rec; end
                end
                3: begin m_left--; if (m_left == 0) m_ph = 4; end
                default: m_ph = 0;
            endcase
            if (cfg_we) begin
                m_setup[cfg_drive] = cfg_setup;
                m_tim[cfg_drive]   = cfg_timing;
                m_mode[cfg_drive]  = cfg_mode;
            end
        end
        #2;
        if (rst_n) begin
            check("R4 ready", req_ready, m_ph == 0);
            check("R1 addr_valid", bus_addr_valid, m_ph >= 1 && m_ph <= 3);
            if (m_ph >= 1 && m_ph <= 3) check("R1 sel_drive", bus_sel_drive, m_drv);
            check("R2 rd_stb", bus_rd_stb, m_ph == 2 && !m_wr);
            check("R2 wr_stb", bus_wr_stb, m_ph == 2 && m_wr);
            check("R7 data_oe", bus_data_oe, m_ph >= 1 && m_ph <= 3 && m_wr);
            if (m_ph >= 1 && m_ph <= 3 && m_wr) check("R7 data_out", bus_data_out, m_wd);
            check("R6 rd_data", rd_data, m_rd);
            check("R4 done", done, m_ph == 4);
            check("R8 err", err, m_ph == 5);
        end
    end

    task automatic set_cfg(input int d, input int s, input int t, input int m);
        @(negedge clk);
        cfg_we = 1; cfg_drive = 2'(d); cfg_setup = 2'(s); cfg_timing = 8'(t); cfg_mode = 2'(m);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // issue one cycle and measure its phases at the ports
    task automatic run_cycle(input int d, input bit wr, input logic [15:0] wd,
                             input int exp_s, input int exp_a, input int exp_r,
                             input bit same_cfg, input int new_tim);
        int ns, na, nr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_drive = 2'(d); req_write = wr; req_wdata = wd;
        if (same_cfg) begin
            cfg_we = 1; cfg_drive = 2'(d); cfg_setup = 2'(m_setup[d]);
            cfg_timing = 8'(new_tim); cfg_mode = 2'(m_mode[d]);
        end
        @(posedge clk); #1;
        req_valid = 0; cfg_we = 0;
        #2;
        ns = 0; na = 0; nr = 0;
        while (bus_addr_valid && !bus_rd_stb && !bus_wr_stb) begin ns++; @(posedge clk); #3; end
        while (bus_rd_stb || bus_wr_stb) begin na++; @(posedge clk); #3; end
        while (bus_addr_valid) begin nr++; @(posedge clk); #3; end
        check("R1 setup length", ns, exp_s);
        check("R2 active length", na, exp_a);
        check("R3 recovery length", nr, exp_r);
        check("R4 done after recovery", done, 1);
        @(posedge clk); #3;
        check("R4 ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state at the ports
        check("R5 ready", req_ready, 1);
        check("R5 addr_valid", bus_addr_valid, 0);
        check("R5 strobes", {bus_rd_stb, bus_wr_stb}, 0);
        check("R5 oe/done/err", {bus_data_oe, done, err}, 0);
        check("R5 rd_data", rd_data, 0);
        rst_n = 1;
        // R5: defaults give setup 3, active 16, recovery 16
        run_cycle(0, 0, 16'h0, 3, 16, 16, 0, 0);
        // fastest setting, setup code 01
        set_cfg(1, 1, 8'h3F, 0);
        run_cycle(1, 1, 16'hBEEF, 2, 3, 1, 0, 0);
        run_cycle(1, 0, 16'h0, 2, 3, 1, 0, 0);
        set_cfg(2, 0, 8'h88, 0);
        run_cycle(2, 0, 16'h0, 4, 8, 9, 0, 0);
        set_cfg(3, 3, 8'hF0, 0);
        run_cycle(3, 1, 16'h5A5A, 5, 15, 16, 0, 0);
        set_cfg(3, 3, 8'h01, 0);
        run_cycle(3, 0, 16'h0, 5, 16, 2, 0, 0);
        // sweep every nibble code on drive 0
        for (int k = 0; k < 16; k++) begin
            set_cfg(0, k % 4, k * 16 + (15 - k), 0);
            run_cycle(0, k[0], 16'(k * 16'h1111), setup_of(k % 4), act_of(k), rec_of(15 - k), 0, 0);
        end
        // R8: refused modes
        set_cfg(2, 2, 8'h22, 3);
        @(negedge clk);
        req_valid = 1; req_drive = 2; req_write = 0;
        @(posedge clk); #1; req_valid = 0; #2;
        check("R8 err pulse", err, 1);
        check("R8 no address", bus_addr_valid, 0);
        @(posedge clk); #3;
        check("R8 err single", err, 0);
        check("R8 ready again", req_ready, 1);
        set_cfg(2, 2, 8'h22, 1);
        @(negedge clk);
        req_valid = 1; req_drive = 2; req_write = 1;
        @(posedge clk); #1; req_valid = 0; #2;
        check("R8 err for mode 01", err, 1);
        // R9: requests held while busy are ignored
        set_cfg(1, 2, 8'h44, 0);
        fork
            run_cycle(1, 0, 16'h0, 3, 4, 5, 0, 0);
            begin
                repeat (4) @(negedge clk);
                req_valid = 1; req_drive = 2; req_write = 1; req_wdata = 16'hDEAD;
                repeat (5) @(negedge clk);
                req_valid = 0;
            end
        join
        check("R9 no refusal from busy request", err, 0);
        // R10: field write on the same clock as acceptance keeps old counts
        run_cycle(1, 0, 16'h0, 3, 4, 5, 1, 8'h2C);
        run_cycle(1, 0, 16'h0, 3, 2, 13, 0, 0);
        // R10: field write in mid-cycle keeps running counts
        fork
            run_cycle(1, 1, 16'h0F0F, 3, 2, 13, 0, 0);
            begin
                repeat (4) @(negedge clk);
                cfg_we = 1; cfg_drive = 1; cfg_setup = 0; cfg_timing = 8'h77; cfg_mode = 0;
                @(negedge clk);
                cfg_we = 0;
            end
        join
        run_cycle(1, 0, 16'h0, 4, 7, 8, 0, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule